// File: doc/BRIEF.md
# Eight-Channel Serial ADC Scan Sequencer

The block is an SPI master that, on one trigger, walks a 12-bit serial converter through all eight input channels without processor involvement. It sends a control byte for each channel, gathers the conversion results, and keeps them in an internal eight-slot result memory. The host reads that memory through a combinational read port.

Transfers overlap. While the control byte for channel n+1 goes out, the result of channel n comes back in the same 16-bit word. A ninth word of all zeros flushes out the channel 7 result. Chip select stays low for the whole scan, so one scan is a continuous stream of 144 serial clocks.

The serial clock comes from the system clock through a programmable half-period divider. When the scan ends, a one-cycle completion pulse is raised, together with a sticky completion flag that stays set until the next accepted trigger.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o is low, busy_o and done_o are low, and all eight result slots read zero.
- R2: A start_i seen while idle drives cs_n_o low and busy_o high from the next cycle. cs_n_o then stays low for exactly 144 rising SCLK edges (nine 16-bit words).
- R3: SPI mode 0 timing applies. SCLK idles low and each SCLK phase lasts DIV_HALF system clocks. MOSI changes only when SCLK falls or when the scan starts. MISO is sampled on rising SCLK edges.
- R4: Words 0 to 7 go out MSB first as {control byte for channel n, 8'h00}. Bit 7 of the control byte is 1 (start). Bits 6:4 are the channel code from CH_CODE[3n+2:3n]. Bits 3:0 are 4'b1111 (unipolar, single-ended, externally clocked). The default channel code for channel n is {n[0], n[2], n[1]}.
- R5: Word 8, the last word of a scan, is all zero.
- R6: The word received during transfer k (k from 1 to 8) goes to result slot k-1. The word received during transfer 0 is discarded.
- R7: The stored result is bits 14:3 of the received word. Bit 15 and bits 2:0 have no effect on the stored result.
- R8: rd_data_o shows the slot selected by rd_addr_i in the same cycle.
- R9: At the end of a scan, done_pulse_o is high for exactly one cycle. In that same cycle cs_n_o returns high, busy_o falls and done_o rises. done_o stays high until the next accepted start.
- R10: A start_i seen while busy_o is high is ignored, including in the cycle in which the scan ends. The scan runs its full length and raises exactly one completion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan trigger |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Sticky scan-complete flag |
| done_pulse_o | output | 1 | One-cycle scan-complete pulse |
| rd_addr_i | input | 3 | Result slot select |
| rd_data_o | output | 12 | Selected result |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Serial data from converter |

## Verification
The coincidence of interest is a trigger that arrives in the same cycle the scan finishes. The scan logic must treat it as ignored, while the completion logic still releases chip select and raises the pulse. The bench provokes this by holding start_i high through an entire scan. It then expects the completion pulse with done_o set. In the following cycle it expects a fresh scan to have been accepted, with done_o cleared, and the chained scan's words and results to match the scoreboard.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NUM_CH    = 8;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int WORD_W    = 16;
  localparam int CTRL_W    = 8;
  localparam int RES_W     = 12;
  localparam int RES_LSB   = 3;
  localparam int NUM_WORDS = NUM_CH + 1;

  // start bit, channel code, unipolar, single-ended, external clock
  function automatic logic [CTRL_W-1:0] ctrl_byte(input logic [CH_W-1:0] code);
    return {1'b1, code, 4'b1111};
  endfunction
endpackage

// File: rtl/scan_clkdiv.sv
module scan_clkdiv #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_W'(DIV_HALF - 1));
  assign rise_o = run_i && wrap && !sclk_o;
  assign fall_o = run_i && wrap && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (load_i) tx_q <= load_word_i;
    else if (fall_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (rise_i) rx_q <= {rx_q[WORD_W-2:0], miso_i};
  end

  assign mosi_o    = tx_q[WORD_W-1];
  // word including the bit being sampled this edge
  assign rx_word_o = {rx_q[WORD_W-2:0], miso_i};
endmodule

// File: rtl/scan_result_mem.sv
module scan_result_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))      mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned             DIV_HALF = 4,
  parameter logic [NUM_CH*CH_W-1:0]  CH_CODE  = 24'hEF2A60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             done_pulse_o,
  input  logic [CH_W-1:0]  rd_addr_i,
  output logic [RES_W-1:0] rd_data_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int WRD_W = $clog2(NUM_WORDS);

  logic [WORD_W-1:0] tx_words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_words
    if (g < NUM_CH) begin : g_ctrl
      assign tx_words[g] = {ctrl_byte(CH_CODE[g*CH_W +: CH_W]), {(WORD_W-CTRL_W){1'b0}}};
    end else begin : g_flush
      assign tx_words[g] = '0;
    end
  end

  logic             busy_q, cs_n_q, done_q, done_pulse_q;
  logic             last_q, pend_q;
  logic [BIT_W-1:0] bit_q;
  logic [WRD_W-1:0] word_q;

  logic              rise, fall, start_ok, word_end, load, wr_en;
  logic [CH_W-1:0]   wr_slot;
  logic [WORD_W-1:0] load_word, rx_word;

  assign start_ok  = start_i && !busy_q;
  assign word_end  = rise && (bit_q == BIT_W'(WORD_W - 1));
  assign wr_en     = word_end && (word_q != '0);
  assign wr_slot   = CH_W'(word_q - 1'b1);
  assign load      = start_ok || (fall && pend_q && !last_q);
  assign load_word = start_ok ? tx_words[0] : tx_words[word_q];

  scan_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  scan_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_word_i (load_word),
    .rise_i      (rise),
    .fall_i      (fall),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_word_o   (rx_word)
  );

  scan_result_mem #(.DEPTH(NUM_CH), .DATA_W(RES_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_slot),
    .wr_data_i (rx_word[RES_LSB +: RES_W]),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      cs_n_q       <= 1'b1;
      done_q       <= 1'b0;
      done_pulse_q <= 1'b0;
      last_q       <= 1'b0;
      pend_q       <= 1'b0;
      bit_q        <= '0;
      word_q       <= '0;
    end else begin
      done_pulse_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        cs_n_q <= 1'b0;
        done_q <= 1'b0;
        last_q <= 1'b0;
        pend_q <= 1'b0;
        bit_q  <= '0;
        word_q <= '0;
      end else if (busy_q) begin
        if (rise) begin
          if (word_end) begin
            bit_q  <= '0;
            pend_q <= 1'b1;
            if (word_q == WRD_W'(NUM_WORDS - 1)) last_q <= 1'b1;
            else                                 word_q <= word_q + 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        if (fall) begin
          if (last_q) begin
            busy_q       <= 1'b0;
            cs_n_q       <= 1'b1;
            done_q       <= 1'b1;
            done_pulse_q <= 1'b1;
            last_q       <= 1'b0;
            pend_q       <= 1'b0;
          end else if (pend_q) begin
            pend_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign cs_n_o       = cs_n_q;
  assign done_o       = done_q;
  assign done_pulse_o = done_pulse_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic done_pulse_o,
  input logic sclk_o,
  input logic cs_n_o,
  input logic mosi_o
);
  a_r3_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);

  a_r3_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  a_r2_cs_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o == !busy_o);

  a_r9_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |=> !done_pulse_o);

  a_r9_pulse_with_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |-> (done_o && cs_n_o && !busy_o));

  a_r9_done_rise_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> done_pulse_o);

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_pulse_o));
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .done_pulse_o (done_pulse_o),
  .sclk_o       (sclk_o),
  .cs_n_o       (cs_n_o),
  .mosi_o       (mosi_o)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int HALF = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic        miso_i = 1'b0;
  logic        busy_o, done_o, done_pulse_o, sclk_o, cs_n_o, mosi_o;
  logic [11:0] rd_data_o;

  adc_scan_seq #(.DIV_HALF(HALF)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .done_pulse_o(done_pulse_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, n_done = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0]  exp_mosi[$];
  logic [11:0]  exp_res[$];
  logic [143:0] pend_stream, cur_stream;

  // R4/R5: expected words from the requirement
  function automatic logic [15:0] exp_word(input int n);
    logic [2:0] c;
    if (n >= 8) return 16'h0000;
    c = {n[0], n[2], n[1]};
    return {1'b1, c, 4'b1111, 8'h00};
  endfunction

  task automatic prepare(input logic [11:0] v [8], input bit junk);
    logic [143:0] s;
    s[143 -: 16] = 16'hA5A5;  // R6: discarded word
    for (int k = 1; k <= 8; k++)
      s[143 - 16*k -: 16] = junk ? {1'b1, v[k-1], 3'b111} : {1'b0, v[k-1], 3'b000};
    pend_stream = s;
    for (int k = 0; k < 9; k++) exp_mosi.push_back(exp_word(k));
    for (int k = 0; k < 8; k++) exp_res.push_back(v[k]);
  endtask

  // converter model
  int r_cnt = 0, b_cnt = 0;
  logic [15:0] mosi_sr;
  time t_rise;
  always @(negedge cs_n_o) begin
    cur_stream = pend_stream;
    r_cnt = 0; b_cnt = 0;
    miso_i = cur_stream[143];
  end
  always @(posedge sclk_o) begin
    t_rise = $time;
    if (!cs_n_o) begin
      mosi_sr = {mosi_sr[14:0], mosi_o};
      r_cnt++; b_cnt++;
      if (b_cnt == 16) begin
        b_cnt = 0;
        if (exp_mosi.size() == 0) check(0, "R4 extra word", mosi_sr, 0);
        else begin
          logic [15:0] e;
          e = exp_mosi.pop_front();
          check(mosi_sr == e, "R4/R5 MOSI word", mosi_sr, e);
        end
      end
    end
  end
  always @(negedge sclk_o) begin
    check(($time - t_rise) == HALF*8, "R3 SCLK high phase", $time - t_rise, HALF*8);
    if (r_cnt < 144) miso_i = cur_stream[143 - r_cnt];
  end
  always @(posedge cs_n_o)
    if (rst_ni) check(r_cnt == 144, "R2 SCLK edges per scan", r_cnt, 144);

  // monitor: reset state, then results at each completion
  initial begin
    @(posedge rst_ni);
    @(negedge clk_i);
    check(cs_n_o && !sclk_o && !busy_o && !done_o, "R1 reset outputs",
          {cs_n_o, sclk_o, busy_o, done_o}, 4'b1000);
    for (int i = 0; i < 8; i++) begin
      rd_addr_i = 3'(i); #1;
      check(rd_data_o == 12'h000, "R1 slot cleared", rd_data_o, 0);
    end
    forever begin
      @(negedge clk_i);
      if (done_pulse_o) begin
        n_done++;
        check(cs_n_o && done_o && !busy_o, "R9 pulse with release",
              {cs_n_o, done_o, busy_o}, 3'b110);
        for (int i = 0; i < 8; i++) begin
          logic [11:0] e;
          rd_addr_i = 3'(i); #1;
          e = (exp_res.size() != 0) ? exp_res.pop_front() : 12'hxxx;
          check(rd_data_o == e, "R6/R7/R8 result slot", rd_data_o, e);
        end
        @(negedge clk_i);
        check(!done_pulse_o, "R9 pulse one cycle", done_pulse_o, 0);
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk_i); while (!done_pulse_o);
  endtask

  initial begin
    logic [11:0] va [8], vb [8], vc [8], vd [8];
    for (int i = 0; i < 8; i++) begin
      va[i] = 12'(12'h111 * (i + 1));
      vb[i] = 12'(12'hFFF - 12'(i * 12'h123));
      vc[i] = (i % 2) ? 12'h000 : 12'hFFF;
      vd[i] = 12'(12'h800 >> i);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk_i);

    // scan A: clean framing
    prepare(va, 0);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    check(busy_o && !cs_n_o, "R2 start accepted", {busy_o, cs_n_o}, 2'b10);
    wait_done();
    repeat (20) @(negedge clk_i);
    check(done_o, "R9 done sticky", done_o, 1);

    // scan B: junk framing bits, mid-scan start ignored
    prepare(vb, 1);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    check(!done_o, "R9 done cleared by start", done_o, 0);
    repeat (300) @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    check(busy_o && !cs_n_o, "R10 start while busy ignored", busy_o, 1);
    wait_done();
    check(n_done == 2, "R10 one pulse per scan", n_done, 2);
    repeat (20) @(negedge clk_i);

    // scans C then D: start held high across the end of C
    prepare(vc, 0);
    start_i = 1'b1;
    @(negedge clk_i);
    prepare(vd, 0);
    wait_done();
    check(done_o && !busy_o, "R10 end-cycle start ignored", {done_o, busy_o}, 2'b10);
    @(negedge clk_i);
    check(busy_o && !done_o && !cs_n_o, "R10 start accepted after end",
          {busy_o, done_o, cs_n_o}, 3'b100);
    start_i = 1'b0;
    wait_done();
    repeat (20) @(negedge clk_i);
    check(exp_mosi.size() == 0 && exp_res.size() == 0, "R5 scoreboard drained",
          exp_mosi.size() + exp_res.size(), 0);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) check(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule